// File: doc/BRIEF.md
# Block Protection and Endurance Configuration Unit

This unit keeps the configuration state of a serial memory of sixteen 512-byte blocks. It stores a write-protected range, given as a first block and a number of blocks. It also stores which single block is the high-endurance block. The bus slave forwards a configuration command to this unit when the most significant bit of the first address byte is set. The unit decodes the first byte and the function byte, and it commits the result only on the command-complete strobe. That strobe is raised by a Stop that follows the third byte. The second byte of such a command carries no information and is not forwarded.

The write sequencer asks, for each target address, whether the address is protected. The bus slave reads back the configuration bytes through a small multiplexer. Protection is a one-shot setting. After a security write with a nonzero count has been accepted, the range and the high-endurance location are frozen for good. The high-endurance block is never reported as protected, even when it lies inside the range.

Top module: `pcfg_top`

## Requirements
- R1: After reset the protected first block is 15, the protected count is 0 and the high-endurance block is 15. No address is protected.
- R2: A strobe with bit 7 of the first byte at 0 is a memory write. It changes no configuration state.
- R3: A configuration write with function-byte bit 7 = 1 and bit 6 = 0 is a security write. It sets the first block from first-byte bits 4..1 and the count from function-byte bits 3..0. First-byte bits 6, 5 and 0 and function-byte bits 5..4 have no effect.
- R4: A configuration write with function-byte bits 7..6 = 00 moves the high-endurance block to first-byte bits 4..1.
- R5: Once a security write with a count above zero has been accepted, later security writes and high-endurance writes are ignored. A security write with count 0 does not freeze anything.
- R6: A configuration command with function-byte bit 6 = 1 is a read. It changes no state.
- R7: The block of an address is bits 12..9. An address is protected when its block b satisfies first <= b < first + count.
- R8: A range that runs past block 15 is clipped at block 15. It never wraps to block 0.
- R9: An address in the high-endurance block is never protected.
- R10: The readback byte always has 1111 in bits 7..4. When function-byte bit 7 = 1, the low nibble is the first block for byte index 0 and the count for index 1. When bit 7 = 0, the low nibble is the high-endurance block for either index.
- R11: Configuration state changes only in the cycle after a strobe. Bytes that change without a strobe have no effect.
- R12: The high-endurance block number is always present on its own output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_addr_hi | input | 8 | First address byte of the command |
| cmd_func | input | 8 | Third (function) byte of the command |
| cmd_done | input | 1 | Command-complete strobe, one cycle |
| rd_idx | input | 1 | Readback byte index (0 first, 1 second) |
| qry_addr | input | 13 | Address asked about by the write sequencer |
| qry_prot | output | 1 | Address is write-protected |
| rd_data | output | 8 | Readback byte for the presented function byte |
| he_blk | output | 4 | Current high-endurance block number |

## Verification
Directed commands place the range at the low end, at the top edge where clipping applies, and around a high-endurance block inside the range. These cases separate a correct range compare from a wrapping one and from one that ignores the override. Random commands are mixed with random don't-care bits. They cover memory writes, reads, count-zero security writes and relocations, and they show whether ignored bits leak into state. A second random phase runs after the freeze, so a lock that fails to block either write kind is caught. Every state change is checked by sweeping one address per block and by reading back both bytes.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;

  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_SEC_WR = 2'd1,
    OP_HE_WR  = 2'd2,
    OP_READ   = 2'd3
  } cfg_op_e;

  localparam int unsigned NIB_W = 4;
  localparam logic [NIB_W-1:0] FILL_NIB = 4'hF;

  // Range test with one guard bit, so first + count never wraps.
  function automatic logic blk_in_span(input logic [NIB_W-1:0] blk,
                                       input logic [NIB_W-1:0] first,
                                       input logic [NIB_W-1:0] cnt);
    logic [NIB_W:0] lim;
    lim = {1'b0, first} + {1'b0, cnt};
    return ({1'b0, blk} >= {1'b0, first}) && ({1'b0, blk} < lim);
  endfunction

  function automatic logic [2*NIB_W-1:0] pack_rb(input logic [NIB_W-1:0] v);
    return {FILL_NIB, v};
  endfunction

endpackage

// File: rtl/pcfg_decode.sv
module pcfg_decode
  import pcfg_pkg::*;
#(
  parameter int unsigned BLK_W = 4
) (
  input  logic [7:0]       addr_hi,
  input  logic [7:0]       func,
  input  logic             done,
  output cfg_op_e          op,
  output logic [BLK_W-1:0] blk_field,
  output logic [BLK_W-1:0] cnt_field
);
  // Bits of the command bytes that carry nothing.
  logic unused_bits;
  assign unused_bits = &{addr_hi[6:5], addr_hi[0], func[5:4]};

  assign blk_field = addr_hi[BLK_W:1];
  assign cnt_field = func[BLK_W-1:0];

  always_comb begin
    op = OP_NONE;
    if (done && addr_hi[7]) begin
      if (func[6])      op = OP_READ;
      else if (func[7]) op = OP_SEC_WR;
      else              op = OP_HE_WR;
    end
  end
endmodule

// File: rtl/pcfg_regs.sv
module pcfg_regs
  import pcfg_pkg::*;
#(
  parameter int unsigned BLK_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cfg_op_e          op,
  input  logic [BLK_W-1:0] blk_field,
  input  logic [BLK_W-1:0] cnt_field,
  output logic [BLK_W-1:0] first_q,
  output logic [BLK_W-1:0] cnt_q,
  output logic [BLK_W-1:0] he_q,
  output logic             frozen_q
);
  localparam logic [BLK_W-1:0] TOP_BLK = '1;

  logic sec_take, he_take;
  assign sec_take = (op == OP_SEC_WR) && !frozen_q;
  assign he_take  = (op == OP_HE_WR)  && !frozen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      first_q  <= TOP_BLK;
      cnt_q    <= '0;
      he_q     <= TOP_BLK;
      frozen_q <= 1'b0;
    end else begin
      if (sec_take) begin
        first_q  <= blk_field;
        cnt_q    <= cnt_field;
        frozen_q <= (cnt_field != '0);
      end
      if (he_take) he_q <= blk_field;
    end
  end

  assert_frozen_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frozen_q |=> ($stable(first_q) && $stable(cnt_q) && $stable(he_q) && frozen_q));

  assert_frozen_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frozen_q |-> (cnt_q != '0));

  assert_quiet_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_NONE) |=> ($stable(first_q) && $stable(cnt_q) && $stable(he_q)));

  assert_read_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_READ) |=> ($stable(first_q) && $stable(cnt_q) && $stable(he_q)));
endmodule

// File: rtl/pcfg_guard.sv
module pcfg_guard
  import pcfg_pkg::*;
#(
  parameter int unsigned BLK_W  = 4,
  parameter int unsigned ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BLK_W-1:0]  first,
  input  logic [BLK_W-1:0]  cnt,
  input  logic [BLK_W-1:0]  he,
  output logic              prot
);
  localparam int unsigned NBLK = 1 << BLK_W;

  logic [NBLK-1:0]  lock_mask;
  logic [BLK_W-1:0] qblk;
  assign qblk = addr[ADDR_W-1 -: BLK_W];

  for (genvar i = 0; i < NBLK; i++) begin : g_blk
    localparam logic [BLK_W-1:0] IDX = BLK_W'(i);
    assign lock_mask[i] = blk_in_span(IDX, first, cnt) && (IDX != he);
  end

  assign prot = lock_mask[qblk];

  assert_he_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (qblk == he) |-> !prot);

  assert_empty_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |-> !prot);

  assert_below_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (qblk < first) |-> !prot);
endmodule

// File: rtl/pcfg_readback.sv
module pcfg_readback
  import pcfg_pkg::*;
#(
  parameter int unsigned BLK_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sec_sel,
  input  logic             idx,
  input  logic [BLK_W-1:0] first,
  input  logic [BLK_W-1:0] cnt,
  input  logic [BLK_W-1:0] he,
  output logic [7:0]       data
);
  logic [BLK_W-1:0] nib;
  always_comb begin
    if (!sec_sel)  nib = he;
    else if (idx)  nib = cnt;
    else           nib = first;
  end
  assign data = pack_rb(nib);

  assert_fill_R10: assert property (@(posedge clk) disable iff (!rst_n)
    data[7:4] == 4'hF);
endmodule

// File: rtl/pcfg_top.sv
module pcfg_top
  import pcfg_pkg::*;
#(
  parameter int unsigned BLK_W  = 4,
  parameter int unsigned ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        cmd_addr_hi,
  input  logic [7:0]        cmd_func,
  input  logic              cmd_done,
  input  logic              rd_idx,
  input  logic [ADDR_W-1:0] qry_addr,
  output logic              qry_prot,
  output logic [7:0]        rd_data,
  output logic [BLK_W-1:0]  he_blk
);
  cfg_op_e          op;
  logic [BLK_W-1:0] blk_field, cnt_field;
  logic [BLK_W-1:0] first_q, cnt_q, he_q;
  logic             frozen_q;

  pcfg_decode #(.BLK_W(BLK_W)) u_dec (
    .addr_hi(cmd_addr_hi), .func(cmd_func), .done(cmd_done),
    .op(op), .blk_field(blk_field), .cnt_field(cnt_field)
  );

  pcfg_regs #(.BLK_W(BLK_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .op(op), .blk_field(blk_field),
    .cnt_field(cnt_field), .first_q(first_q), .cnt_q(cnt_q),
    .he_q(he_q), .frozen_q(frozen_q)
  );

  pcfg_guard #(.BLK_W(BLK_W), .ADDR_W(ADDR_W)) u_guard (
    .clk(clk), .rst_n(rst_n), .addr(qry_addr), .first(first_q),
    .cnt(cnt_q), .he(he_q), .prot(qry_prot)
  );

  pcfg_readback #(.BLK_W(BLK_W)) u_rb (
    .clk(clk), .rst_n(rst_n), .sec_sel(cmd_func[7]), .idx(rd_idx),
    .first(first_q), .cnt(cnt_q), .he(he_q), .data(rd_data)
  );

  assign he_blk = he_q;

  assert_plain_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done && !cmd_addr_hi[7]) |=> $stable(he_blk));

  assert_he_out_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_func[7]) |-> (rd_data[3:0] == he_blk));
endmodule

// File: tb/tb_pcfg_top.sv
`timescale 1ns/1ps
module tb_pcfg_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cmd_addr_hi = '0;
  logic [7:0]  cmd_func = '0;
  logic        cmd_done = 1'b0;
  logic        rd_idx = 1'b0;
  logic [12:0] qry_addr = '0;
  logic        qry_prot;
  logic [7:0]  rd_data;
  logic [3:0]  he_blk;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [3:0] m_first, m_cnt, m_he;
  bit m_frozen;

  always #2.5 clk = ~clk;

  pcfg_top dut (
    .clk(clk), .rst_n(rst_n), .cmd_addr_hi(cmd_addr_hi), .cmd_func(cmd_func),
    .cmd_done(cmd_done), .rd_idx(rd_idx), .qry_addr(qry_addr),
    .qry_prot(qry_prot), .rd_data(rd_data), .he_blk(he_blk)
  );

  function automatic bit exp_prot(input logic [12:0] a);
    int b, lo, hi;
    b  = int'(a[12:9]);
    lo = int'(m_first);
    hi = lo + int'(m_cnt) - 1;
    if (hi > 15) hi = 15;
    return (b >= lo) && (b <= hi) && (b != int'(m_he));
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_cmd(input logic [7:0] hi, input logic [7:0] fn);
    if (!hi[7] || fn[6] || m_frozen) return;
    if (fn[7]) begin
      m_first  = hi[4:1];
      m_cnt    = fn[3:0];
      m_frozen = (fn[3:0] != 0);
    end else m_he = hi[4:1];
  endtask

  task automatic send(input logic [7:0] hi, input logic [7:0] fn);
    @(negedge clk);
    cmd_addr_hi = hi; cmd_func = fn; cmd_done = 1'b1;
    @(negedge clk);
    cmd_done = 1'b0;
    model_cmd(hi, fn);
  endtask

  task automatic sweep(input string req);
    for (int b = 0; b < 16; b++) begin
      qry_addr = {b[3:0], 9'($urandom)};
      #1;
      chk(req, qry_prot, exp_prot(qry_addr));
    end
    chk("R12 he_blk", he_blk, m_he);
  endtask

  task automatic readback(input string req);
    cmd_func = 8'h80 | 8'($urandom & 8'h3F);
    rd_idx = 1'b0; #1;
    chk(req, rd_data, {4'hF, m_first});
    rd_idx = 1'b1; #1;
    chk(req, rd_data, {4'hF, m_cnt});
    cmd_func = 8'($urandom & 8'h7F);
    rd_idx = 1'($urandom); #1;
    chk(req, rd_data, {4'hF, m_he});
  endtask

  function automatic logic [7:0] junk_hi(input logic [3:0] blk);
    logic [7:0] r;
    r = 8'($urandom);
    return {1'b1, r[6:5], blk, r[0]};
  endfunction

  initial begin
    #(200000 * 5);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired (R1..)");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_first = 4'd15; m_cnt = 4'd0; m_he = 4'd15; m_frozen = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    sweep("R1 reset prot");
    readback("R1 reset readback");

    // R2 memory write with a security pattern has no effect
    send(8'h0A, 8'h85);
    sweep("R2 plain write");
    readback("R2 plain write");

    // R11 bytes wiggle with no strobe
    @(negedge clk);
    cmd_addr_hi = 8'h86; cmd_func = 8'h87;
    repeat (3) @(negedge clk);
    sweep("R11 no strobe");
    readback("R11 no strobe");

    // R4 relocate with junk bits set
    send(8'hE7, 8'h30);
    chk("R4 he relocate", he_blk, 3);
    sweep("R4 sweep");

    // R3 count-zero security write: no freeze
    send(8'hEC, 8'hB0);
    readback("R3 count zero");
    send(8'h92, 8'h00);
    chk("R5 relocate after count zero", he_blk, 9);

    // R6 read commands change nothing
    send(8'h84, 8'hC7);
    send(8'h84, 8'h47);
    readback("R6 read cmd");
    sweep("R6 read cmd");

    // random phase before the freeze
    for (int i = 0; i < 300; i++) begin
      int k;
      logic [7:0] hi, fn;
      k  = $urandom % 4;
      hi = junk_hi(4'($urandom));
      fn = 8'($urandom);
      case (k)
        0: hi[7] = 1'b0;
        1: fn = {2'b10, fn[5:4], 4'h0};
        2: fn = {2'b00, fn[5:0]};
        default: fn[6] = 1'b1;
      endcase
      send(hi, fn);
      sweep("R7 random");
      readback("R10 random");
    end

    // R8/R9 clipped range with the endurance block inside it
    send(junk_hi(4'd13), 8'h05);
    send(junk_hi(4'd12), 8'hB7);
    sweep("R8 R9 clip override");
    qry_addr = 13'h1A00; #1; chk("R8 block13 he", qry_prot, 0);
    qry_addr = 13'h1C10; #1; chk("R8 block14", qry_prot, 1);
    qry_addr = 13'h0005; #1; chk("R8 no wrap block0", qry_prot, 0);
    qry_addr = 13'h1FFF; #1; chk("R8 block15", qry_prot, 1);
    readback("R3 locked values");

    // R5 after freeze everything is ignored
    for (int i = 0; i < 200; i++) begin
      logic [7:0] fn;
      fn = 8'($urandom);
      fn[6] = 1'b0;
      send(junk_hi(4'($urandom)), fn);
      sweep("R5 frozen");
      readback("R5 frozen");
    end
    chk("R5 he kept", he_blk, 13);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule